// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block turns a stream of visible pixel positions on a fixed 640 by 480 true-color display into word fetches from a framebuffer held in external memory. It also turns the words that memory returns into 8-bit red, green and blue outputs. Each pixel occupies one 32-bit word. Each framebuffer row is 1024 words wide, and only its first 640 words are ever fetched. The framebuffer base is taken from the top 11 bits of a base register, so the buffer sits on a 2 MiB boundary.

Two registers sit behind a word-indexed write port. Index 0 holds the base. Index 1 holds the control bits: bit 0 switches the display on, and bit 1 turns the picture through 180 degrees. Both registers read back exactly as written. A new base or rotate setting takes effect only at the first pixel of a frame. The enable bit acts at once.

Position input and fetch output form a valid/ready pair. While the display is enabled, a position is accepted only when the memory accepts the fetch, so `pos_ready` mirrors `fetch_ready`. The source must hold the position and its valid high until it is taken. While the display is disabled, positions are drained at once and no fetch is issued. Read responses carry no back-pressure. Each response produces one output pixel one cycle later.

Top module: `scan_fetch_top`

## Requirements
- R1: After reset both registers read 0, the display is disabled, `fetch_valid` and `pix_valid` are low and the colour outputs are 0.
- R2: A write to index 0 (base) or index 1 (control) stores all 32 bits, and the register reads back that value on `cfg_rd_data` from the next cycle on.
- R3: When enabled and not rotated, position (x, y) fetches byte address base_hi + (y*1024 + x)*4. Here base_hi is the base register with bits 20:0 cleared. Columns 640 to 1023 of a row are never addressed.
- R4: Bits 20:0 of the base register have no effect on any fetch address.
- R5: While control bit 0 is 0, `fetch_valid` stays low, `pos_ready` is high, and the colour outputs are 0 from the next cycle. Writing 0 to control turns the display off in the cycle after the write.
- R6: When control bit 1 is set, position (x, y) fetches the word of column 639-x in row 479-y.
- R7: A changed base or rotate bit is first used for the position (0, 0) that is accepted after the write. Until then, every fetch uses the settings latched at the previous accepted (0, 0).
- R8: A response with `rsp_valid` high gives `pix_valid` high one cycle later. In that cycle red is data bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 are ignored. Without a response, `pix_valid` is low.
- R9: While enabled, `pos_ready` equals `fetch_ready`, and `fetch_valid` equals `pos_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 1 | Write index: 0 base, 1 control |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_idx | input | 1 | Read index: 0 base, 1 control |
| cfg_rd_data | output | 32 | Read data of the selected register |
| pos_valid | input | 1 | Pixel position valid |
| pos_ready | output | 1 | Pixel position accepted |
| pos_x | input | 10 | Visible column, 0 to 639 |
| pos_y | input | 9 | Visible line, 0 to 479 |
| fetch_valid | output | 1 | Fetch request valid |
| fetch_ready | input | 1 | Memory accepts the fetch |
| fetch_addr | output | 32 | Fetch byte address |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 32 | Returned pixel word |
| pix_valid | output | 1 | Colour outputs carry a pixel |
| pix_red | output | 8 | Red level |
| pix_green | output | 8 | Green level |
| pix_blue | output | 8 | Blue level |

## Verification
The assertions take for granted that `pos_x` stays below 640 and `pos_y` below 480. The column-range property depends on this. They also take for granted that responses never need back-pressure. The stimulus draws positions only from the visible range, and it holds a position steady until `pos_ready` accepts it. It drives responses freely in any cycle, because the block never refuses one.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int ENABLE_BIT = 0;
  localparam int ROTATE_BIT = 1;

  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;

  localparam int CHANNELS = 3;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BASE_BITS = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_idx,
  input  logic [ADDR_W-1:0]    wr_data,
  input  logic                 rd_idx,
  output logic [ADDR_W-1:0]    rd_data,
  input  logic                 frame_start,
  input  logic                 frame_take,
  output logic                 disp_en,
  output logic [BASE_BITS-1:0] use_base,
  output logic                 use_rot
);
  logic [ADDR_W-1:0]    base_q;
  logic [ADDR_W-1:0]    ctrl_q;
  logic [BASE_BITS-1:0] act_base_q;
  logic                 act_rot_q;
  logic [BASE_BITS-1:0] live_base;
  logic                 live_rot;

  assign live_base = base_q[ADDR_W-1 -: BASE_BITS];
  assign live_rot  = ctrl_q[ROTATE_BIT];
  assign disp_en   = ctrl_q[ENABLE_BIT];

  // The first pixel of a frame already sees freshly written settings.
  assign use_base = frame_start ? live_base : act_base_q;
  assign use_rot  = frame_start ? live_rot  : act_rot_q;

  always_comb begin
    rd_data = (reg_sel_e'(rd_idx) == SEL_CTRL) ? ctrl_q : base_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      ctrl_q     <= '0;
      act_base_q <= '0;
      act_rot_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (reg_sel_e'(wr_idx) == SEL_CTRL) ctrl_q <= wr_data;
        else                                base_q <= wr_data;
      end
      if (frame_take) begin
        act_base_q <= live_base;
        act_rot_q  <= live_rot;
      end
    end
  end

  // R7: latched frame settings move only on an accepted first pixel
  a_r7_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_take |=> ($stable(act_base_q) && $stable(act_rot_q)));
endmodule

// File: rtl/scan_addr.sv
module scan_addr #(
  parameter int ADDR_W     = 32,
  parameter int BASE_BITS  = 11,
  parameter int H_PIX      = 640,
  parameter int V_LINES    = 480,
  parameter int PITCH_LOG2 = 10,
  parameter int XW         = 10,
  parameter int YW         = 9
) (
  input  logic [XW-1:0]        x,
  input  logic [YW-1:0]        y,
  input  logic [BASE_BITS-1:0] base_hi,
  input  logic                 rot,
  output logic [ADDR_W-1:0]    addr
);
  localparam int LOW_W = ADDR_W - BASE_BITS;
  localparam int BYTE_SHIFT = 2;

  logic [XW-1:0]     col;
  logic [YW-1:0]     row;
  logic [ADDR_W-1:0] word_off;

  always_comb begin
    col = rot ? XW'(H_PIX - 1 - int'(x))   : x;
    row = rot ? YW'(V_LINES - 1 - int'(y)) : y;
    word_off = (ADDR_W'(row) << PITCH_LOG2) + ADDR_W'(col);
    addr = {base_hi, {LOW_W{1'b0}}} + (word_off << BYTE_SHIFT);
  end
endmodule

// File: rtl/scan_unpack.sv
module scan_unpack
  import scan_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              pix_valid,
  output logic [CW-1:0]     chan [CHANNELS]
);
  // chan[0] = red (bits 23:16), chan[1] = green, chan[2] = blue (bits 7:0)
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    localparam int LSB = (CHANNELS - 1 - c) * CW;
    always_ff @(posedge clk) begin
      if (!rst_n)         chan[c] <= '0;
      else if (!disp_en)  chan[c] <= '0;
      else if (rsp_valid) chan[c] <= rsp_data[LSB +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_valid <= 1'b0;
    else        pix_valid <= rsp_valid;
  end

  // R8: fixed one-cycle latency from response to pixel
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> pix_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> !pix_valid);
  // R5: disabled display shows black
  a_r5_black: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |=> (chan[0] == '0 && chan[1] == '0 && chan[2] == '0));
endmodule

// File: rtl/scan_fetch_top.sv
module scan_fetch_top
  import scan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BASE_BITS  = 11,
  parameter int H_PIX      = 640,
  parameter int V_LINES    = 480,
  parameter int PITCH_LOG2 = 10,
  parameter int CW         = 8,
  parameter int XW         = $clog2(H_PIX),
  parameter int YW         = $clog2(V_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_wr_idx,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  input  logic              cfg_rd_idx,
  output logic [ADDR_W-1:0] cfg_rd_data,
  input  logic              pos_valid,
  output logic              pos_ready,
  input  logic [XW-1:0]     pos_x,
  input  logic [YW-1:0]     pos_y,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              pix_valid,
  output logic [CW-1:0]     pix_red,
  output logic [CW-1:0]     pix_green,
  output logic [CW-1:0]     pix_blue
);
  logic                 disp_en;
  logic                 frame_start;
  logic                 frame_take;
  logic [BASE_BITS-1:0] use_base;
  logic                 use_rot;
  logic [CW-1:0]        chan [CHANNELS];

  assign frame_start = pos_valid && (pos_x == '0) && (pos_y == '0);
  assign pos_ready   = disp_en ? fetch_ready : 1'b1;
  assign fetch_valid = pos_valid && disp_en;
  assign frame_take  = frame_start && pos_ready;

  scan_regs #(
    .ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
    .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data),
    .frame_start(frame_start), .frame_take(frame_take),
    .disp_en(disp_en), .use_base(use_base), .use_rot(use_rot)
  );

  scan_addr #(
    .ADDR_W(ADDR_W), .BASE_BITS(BASE_BITS), .H_PIX(H_PIX), .V_LINES(V_LINES),
    .PITCH_LOG2(PITCH_LOG2), .XW(XW), .YW(YW)
  ) u_addr (
    .x(pos_x), .y(pos_y), .base_hi(use_base), .rot(use_rot), .addr(fetch_addr)
  );

  scan_unpack #(
    .DATA_W(DATA_W), .CW(CW)
  ) u_unpack (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pix_valid(pix_valid), .chan(chan)
  );

  assign pix_red   = chan[0];
  assign pix_green = chan[1];
  assign pix_blue  = chan[2];

  // R5: a disabled display drains positions without fetching
  a_r5_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && !disp_en) |-> (pos_ready && !fetch_valid));
  // R3: the column field of a fetch never reaches the row padding
  a_r3_pad_skip: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (int'(fetch_addr[PITCH_LOG2+1:2]) < H_PIX));
  // R9: an enabled stall holds the position
  a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |-> !pos_ready);
endmodule

// File: tb/test_scan_fetch_top.sv
module test_scan_fetch_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_wr_idx = 1'b0, cfg_rd_idx = 1'b0;
  logic [31:0] cfg_wr_data = '0, cfg_rd_data;
  logic        pos_valid = 1'b0, pos_ready;
  logic [9:0]  pos_x = '0;
  logic [8:0]  pos_y = '0;
  logic        fetch_valid, fetch_ready = 1'b0;
  logic [31:0] fetch_addr;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        pix_valid;
  logic [7:0]  pix_red, pix_green, pix_blue;

  int checks = 0, errors = 0;
  bit done = 0;
  bit took = 0;

  // reference model state
  logic [31:0] m_base, m_ctrl, m_act_base;
  logic        m_act_rot, m_pv;
  logic [7:0]  m_r, m_g, m_b;

  always #2 clk = ~clk;

  scan_fetch_top i_scan_fetch_top (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
    .pos_valid(pos_valid), .pos_ready(pos_ready), .pos_x(pos_x), .pos_y(pos_y),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_addr(input logic [31:0] b, input bit rot,
                                           input int x, input int y);
    int c, r;
    c = rot ? 639 - x : x;
    r = rot ? 479 - y : y;
    return (b & 32'hFFE0_0000) + 32'((r * 1024 + c) * 4);
  endfunction

  // cycle model, compared at every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_ctrl = 0; m_act_base = 0; m_act_rot = 0;
      m_pv = 0; m_r = 0; m_g = 0; m_b = 0; took = 0;
    end else begin
      bit en, sof, erdy, efv, urot;
      logic [31:0] ubase, eaddr;
      en    = m_ctrl[0];
      sof   = pos_valid && pos_x == 0 && pos_y == 0;
      erdy  = en ? fetch_ready : 1'b1;
      efv   = pos_valid && en;
      ubase = sof ? m_base : m_act_base;
      urot  = sof ? m_ctrl[1] : m_act_rot;
      eaddr = ref_addr(ubase, urot, int'(pos_x), int'(pos_y));
      chk(pos_ready == erdy, "R9 pos_ready", 32'(pos_ready), 32'(erdy));
      chk(fetch_valid == efv, "R5 fetch_valid", 32'(fetch_valid), 32'(efv));
      if (efv) chk(fetch_addr == eaddr, "R3 R4 R6 R7 fetch_addr", fetch_addr, eaddr);
      chk(cfg_rd_data == (cfg_rd_idx ? m_ctrl : m_base), "R2 readback", cfg_rd_data,
          cfg_rd_idx ? m_ctrl : m_base);
      chk(pix_valid == m_pv, "R8 pix_valid", 32'(pix_valid), 32'(m_pv));
      chk({pix_red, pix_green, pix_blue} == {m_r, m_g, m_b}, "R8 R5 colour",
          32'({pix_red, pix_green, pix_blue}), 32'({m_r, m_g, m_b}));
      // state after the coming rising edge
      took = pos_valid && erdy;
      if (sof && erdy) begin m_act_base = m_base; m_act_rot = m_ctrl[1]; end
      m_pv = rsp_valid;
      if (!en) begin m_r = 0; m_g = 0; m_b = 0; end
      else if (rsp_valid) begin m_r = rsp_data[23:16]; m_g = rsp_data[15:8]; m_b = rsp_data[7:0]; end
      if (cfg_wr_en) begin
        if (cfg_wr_idx) m_ctrl = cfg_wr_data; else m_base = cfg_wr_data;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cfg_wr_en = 0; rsp_valid = 0;
  endtask

  task automatic wr(input bit idx, input logic [31:0] d);
    cfg_wr_en = 1; cfg_wr_idx = idx; cfg_wr_data = d;
    step();
  endtask

  task automatic put(input int x, input int y);
    pos_valid = 1; pos_x = 10'(x); pos_y = 9'(y);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(cfg_rd_data == 0, "R1 base reset", cfg_rd_data, 0);
    chk(!fetch_valid && !pix_valid, "R1 idle", 32'({fetch_valid, pix_valid}), 0);
    chk({pix_red, pix_green, pix_blue} == 0, "R1 colour", 32'({pix_red, pix_green, pix_blue}), 0);
    step();
    wr(0, 32'h1234_5678);
    wr(1, 32'h0000_0001);
    cfg_rd_idx = 1; fetch_ready = 1;
    @(negedge clk);
    chk(cfg_rd_data == 32'h1, "R2 ctrl readback", cfg_rd_data, 32'h1);
    step();
    put(0, 0); @(negedge clk);
    chk(fetch_addr == 32'h1220_0000, "R4 low base bits", fetch_addr, 32'h1220_0000);
    step(); put(5, 2); @(negedge clk);
    chk(fetch_addr == 32'h1220_2014, "R3 addr", fetch_addr, 32'h1220_2014);
    step(); put(639, 479); @(negedge clk);
    chk(fetch_addr == 32'h123D_F9FC, "R3 last pixel", fetch_addr, 32'h123D_F9FC);
    step(); pos_valid = 0;
    wr(1, 32'h3);
    put(5, 2); @(negedge clk);
    chk(fetch_addr == 32'h1220_2014, "R7 rotate deferred", fetch_addr, 32'h1220_2014);
    step(); put(0, 0); @(negedge clk);
    chk(fetch_addr == 32'h123D_F9FC, "R6 rotated origin", fetch_addr, 32'h123D_F9FC);
    step(); put(639, 479); @(negedge clk);
    chk(fetch_addr == 32'h1220_0000, "R6 rotated corner", fetch_addr, 32'h1220_0000);
    step(); pos_valid = 0; rsp_valid = 1; rsp_data = 32'hAB11_2233;
    @(posedge clk); #1 rsp_valid = 0; @(negedge clk);
    chk(pix_valid && {pix_red, pix_green, pix_blue} == 24'h112233, "R8 unpack",
        32'({pix_red, pix_green, pix_blue}), 32'h112233);
    step(); fetch_ready = 0; put(7, 7); @(negedge clk);
    chk(!pos_ready && fetch_valid, "R9 stall", 32'({pos_ready, fetch_valid}), 32'b01);
    step(); pos_valid = 0; fetch_ready = 1;
    wr(1, 32'h0);
    put(7, 7); rsp_valid = 1; rsp_data = 32'h00FF_FFFF; @(negedge clk);
    chk(pos_ready && !fetch_valid, "R5 off drains", 32'({pos_ready, fetch_valid}), 32'b10);
    @(posedge clk); #1 rsp_valid = 0; pos_valid = 0; @(negedge clk);
    chk({pix_red, pix_green, pix_blue} == 0, "R5 black", 32'({pix_red, pix_green, pix_blue}), 0);
    // random phase: the per-cycle model carries the checks
    for (int i = 0; i < 4000; i++) begin
      int k;
      if (!pos_valid || took) begin
        k = int'($urandom_range(0, 9));
        if (k < 2)       put(0, 0);
        else if (k == 2) put(639, 479);
        else if (k < 9) put(int'($urandom_range(0, 639)), int'($urandom_range(0, 479)));
        else pos_valid = 0;
      end
      fetch_ready = ($urandom_range(0, 3) != 0);
      cfg_rd_idx  = 1'($urandom);
      k = int'($urandom_range(0, 49));
      if (k == 0) begin
        cfg_wr_en = 1; cfg_wr_idx = 0; cfg_wr_data = $urandom;
      end else if (k == 1) begin
        cfg_wr_en = 1; cfg_wr_idx = 1;
        cfg_wr_data = {$urandom_range(0, 255), 22'h0, 2'($urandom_range(0, 3))} | 32'h1;
      end else if (k == 2) begin
        cfg_wr_en = 1; cfg_wr_idx = 1; cfg_wr_data = 32'h0;
      end
      if ($urandom_range(0, 2) == 0) begin rsp_valid = 1; rsp_data = $urandom; end
      @(posedge clk); #1;
      cfg_wr_en = 0; rsp_valid = 0;
    end
    pos_valid = 0;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule